// File: doc/BRIEF.md
# Single-Channel Register-File DMA Engine

This block is one DMA channel that copies data between a peripheral control register and a location in an on-chip register file. The copy can run in either direction. Software first sets a start address, an end address, a peripheral address and a control word. After that, each request pulse on the selected trigger line starts one transfer. For each transfer the channel asks the CPU for the shared bus and waits for the grant. It then moves one byte, or one two-byte word as two consecutive bytes with the low byte first, and gives the bus back.

The channel keeps a current register-file address. After each transfer it either steps this address forward by the transfer size or, at the end of the block, reloads it from the start address. At the end of the block it can raise an interrupt pulse. Depending on its mode it then either keeps running or switches itself off. Each byte moves as a read bus cycle from the source and then a write bus cycle to the destination.

Top module: `pdma_channel`

## Requirements
- R1: A transfer starts only when the channel is idle, the enable bit (control bit 0) is 1 and the trigger line picked by the select field (control bits 6:5) is high at a clock edge. A trigger on any other line, a trigger while disabled and a trigger while a transfer is in progress are dropped and are not queued.
- R2: `bus_req` rises in the cycle after an accepted trigger. No read or write cycle appears until `bus_gnt` is high. Reads and writes only happen while `bus_req` is high.
- R3: Byte mode (control bit 2 = 0) makes one read cycle followed by one write cycle. Word mode (bit 2 = 1) makes two such read-write pairs. The first pair is at the lower address and the second pair at the next address, on both the register-file side and the peripheral side.
- R4: With control bit 1 = 0, data goes from the peripheral (`bus_space` = 1) to the register file (`bus_space` = 0). With bit 1 = 1, data goes from the register file to the peripheral.
- R5: After a transfer, if the current address differs from the end address, the current address grows by 1 in byte mode or by 2 in word mode.
- R6: After a transfer, if the current address equals the end address, the current address is reloaded with the start address.
- R7: `irq_o` is high for exactly one cycle, the cycle after the final write of an end-of-block transfer. This happens only if control bit 3 is 1.
- R8: With control bit 4 = 0 (single pass), the enable bit clears at the end of the block. With bit 4 = 1 (looping), it stays set.
- R9: `bus_req` is low in the cycle after the final write cycle of a transfer.
- R10: A write to the start register (select 1) also loads the current address, but only while the enable bit is 0. The end register uses select 2, the peripheral address register uses select 3 and the control word uses select 0.
- R11: If software writes the control word in the same cycle that single-pass end-of-block would clear the enable bit, the software value is taken, including its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 start, 2 end, 3 peripheral address |
| cfg_wdata | input | 12 | Configuration write data |
| trig_in | input | 4 | Trigger request lines |
| en_o | output | 1 | Current enable bit |
| cur_addr_o | output | 12 | Current register-file address |
| irq_o | output | 1 | End-of-block interrupt pulse |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_space | output | 1 | Address space: 1 peripheral, 0 register file |
| bus_addr | output | 12 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |

## Verification
Two events can land on the same clock edge: single-pass end-of-block clearing the enable bit, and a software write to the control word. The bench watches the bus for the final write cycle of a single-pass transfer and drives a control write with enable set in that same cycle. It then checks that the enable bit stays 1, that the address still reloads and the interrupt still fires, and that a later trigger is still served. It also checks the plain single-pass case on its own, where the enable bit does drop, so the two outcomes can be told apart.

// File: rtl/pdma_pkg.sv
// Shared types for the DMA channel: register selects, control word
// layout and sequencer states. Assumes ADDR_W >= 5 + trigger select width.
package pdma_pkg;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_START = 2'd1,
        SEL_END   = 2'd2,
        SEL_PERI  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_state_e;

    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_DIR  = 1;
    localparam int unsigned CB_WORD = 2;
    localparam int unsigned CB_IE   = 3;
    localparam int unsigned CB_LOOP = 4;
    localparam int unsigned CB_TSEL = 5;
endpackage

// File: rtl/pdma_regs.sv
// Configuration register bank: control fields, start, end and peripheral
// address. Assumes one write per cycle; a software write of the control
// word has priority over the hardware enable clear in the same cycle.
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned TSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              hw_clr_en,
    output logic              en,
    output logic              dir,
    output logic              word,
    output logic              ie,
    output logic              loop_mode,
    output logic [TSEL_W-1:0] tsel,
    output logic [ADDR_W-1:0] start_a,
    output logic [ADDR_W-1:0] end_a,
    output logic [ADDR_W-1:0] peri_a
);
    logic wr_ctrl;
    assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);

    // Control word fields; software write wins over self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            dir       <= 1'b0;
            word      <= 1'b0;
            ie        <= 1'b0;
            loop_mode <= 1'b0;
            tsel      <= '0;
        end else if (wr_ctrl) begin
            en        <= cfg_wdata[CB_EN];
            dir       <= cfg_wdata[CB_DIR];
            word      <= cfg_wdata[CB_WORD];
            ie        <= cfg_wdata[CB_IE];
            loop_mode <= cfg_wdata[CB_LOOP];
            tsel      <= cfg_wdata[CB_TSEL +: TSEL_W];
        end else if (hw_clr_en) begin
            en <= 1'b0;
        end
    end

    // Address registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_a <= '0;
            end_a   <= '0;
            peri_a  <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_START: start_a <= cfg_wdata;
                SEL_END:   end_a   <= cfg_wdata;
                SEL_PERI:  peri_a  <= cfg_wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/pdma_cursor.sv
// Current register-file address. It is loaded by a start-register write
// while disabled, and stepped or reloaded at the end of each transfer.
// Assumes a step and a load never coincide (a step needs enable set).
module pdma_cursor
    import pdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              word,
    input  logic [ADDR_W-1:0] start_a,
    input  logic [ADDR_W-1:0] end_a,
    output logic [ADDR_W-1:0] cur_a,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    assign at_end = (cur_a == end_a);

    // Address update: software load, block-end reload or forward step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_a <= '0;
        end else if (load_start) begin
            cur_a <= load_val;
        end else if (step) begin
            if (at_end) cur_a <= start_a;
            else        cur_a <= cur_a + (word ? TWO : ONE);
        end
    end
endmodule

// File: rtl/pdma_seq.sv
// Transfer sequencer: trigger acceptance, bus request and grant wait,
// read/write beats, and the end-of-block interrupt pulse. Assumes the
// grant stays high once given until the request drops.
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NTRIG  = 4,
    parameter int unsigned TSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTRIG-1:0]  trig_in,
    input  logic              en,
    input  logic              dir,
    input  logic              word,
    input  logic              ie,
    input  logic [TSEL_W-1:0] tsel,
    input  logic [ADDR_W-1:0] cur_a,
    input  logic [ADDR_W-1:0] peri_a,
    input  logic              at_end,
    output logic              step,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_space,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    seq_state_e        state_q;
    logic              hi_q;
    logic [DATA_W-1:0] data_q;
    logic              trig_hit;
    logic              last_beat;
    logic [ADDR_W-1:0] rf_addr;
    logic [ADDR_W-1:0] pr_addr;

    assign trig_hit  = en && trig_in[tsel];
    assign last_beat = !word || hi_q;
    assign step      = (state_q == ST_WR) && last_beat;
    assign rf_addr   = cur_a + ADDR_W'(hi_q);
    assign pr_addr   = peri_a + ADDR_W'(hi_q);

    // State progression of one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hi_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    hi_q <= 1'b0;
                    if (trig_hit) state_q <= ST_REQ;
                end
                ST_REQ:  if (bus_gnt) state_q <= ST_RD;
                ST_RD:   state_q <= ST_WR;
                ST_WR: begin
                    if (last_beat) begin
                        state_q <= ST_IDLE;
                        hi_q    <= 1'b0;
                    end else begin
                        state_q <= ST_RD;
                        hi_q    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the source byte during the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (state_q == ST_RD)  data_q <= bus_rdata;
    end

    // One-cycle interrupt after an end-of-block transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= step && at_end && ie;
    end

    // Bus outputs from the state; the source side is read, the destination side written.
    always_comb begin
        bus_req   = (state_q != ST_IDLE);
        bus_rd    = (state_q == ST_RD);
        bus_wr    = (state_q == ST_WR);
        bus_wdata = bus_wr ? data_q : '0;
        bus_space = 1'b0;
        bus_addr  = '0;
        if (bus_rd) begin
            bus_space = !dir;
            bus_addr  = dir ? rf_addr : pr_addr;
        end else if (bus_wr) begin
            bus_space = dir;
            bus_addr  = dir ? pr_addr : rf_addr;
        end
    end
endmodule

// File: rtl/pdma_channel.sv
// Top of the DMA channel: register bank, address cursor and sequencer.
// Assumes the bus fabric returns read data combinationally in the read cycle.
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NTRIG  = 4,
    localparam int unsigned TSEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [NTRIG-1:0]  trig_in,
    output logic              en_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              irq_o,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_space,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic              en, dir, word, ie, loop_mode;
    logic [TSEL_W-1:0] tsel;
    logic [ADDR_W-1:0] start_a, end_a, peri_a, cur_a;
    logic              step, at_end, hw_clr_en, load_start;

    assign hw_clr_en  = step && at_end && !loop_mode;
    assign load_start = cfg_we && (cfg_sel == SEL_START) && !en;
    assign en_o       = en;
    assign cur_addr_o = cur_a;

    pdma_regs #(.ADDR_W(ADDR_W), .TSEL_W(TSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hw_clr_en(hw_clr_en), .en(en), .dir(dir),
        .word(word), .ie(ie), .loop_mode(loop_mode), .tsel(tsel),
        .start_a(start_a), .end_a(end_a), .peri_a(peri_a)
    );

    pdma_cursor #(.ADDR_W(ADDR_W)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load_start(load_start),
        .load_val(cfg_wdata), .step(step), .word(word), .start_a(start_a),
        .end_a(end_a), .cur_a(cur_a), .at_end(at_end)
    );

    pdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NTRIG(NTRIG),
               .TSEL_W(TSEL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .en(en), .dir(dir),
        .word(word), .ie(ie), .tsel(tsel), .cur_a(cur_a), .peri_a(peri_a),
        .at_end(at_end), .step(step), .irq(irq_o), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/pdma_channel_chk.sv
// Port-level protocol checks for the DMA channel, bound to the top.
module pdma_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [1:0] cfg_sel,
    input logic       en_o,
    input logic       irq_o,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       bus_rd,
    input logic       bus_wr
);
    // R2
    rdwr_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_req && bus_gnt));

    // R2
    req_first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (!bus_rd && !bus_wr));

    // R3
    rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R3
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));

    // R9
    req_drop_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(bus_wr));

    // R7
    irq_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(bus_wr));

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R8
    en_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_o) |-> ($past(bus_wr) || $past(cfg_we && cfg_sel == 2'd0)));
endmodule

bind pdma_channel pdma_channel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .en_o(en_o), .irq_o(irq_o), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_rd(bus_rd), .bus_wr(bus_wr)
);

// File: tb/pdma_channel_test.sv
module pdma_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [11:0] cfg_wdata = '0;
    logic [3:0]  trig_in = '0;
    logic        en_o, irq_o, bus_req, bus_gnt, bus_rd, bus_wr, bus_space;
    logic [11:0] cur_addr_o, bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        gnt_allow = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int viol  = 0;

    logic [7:0] rf  [0:255];
    logic [7:0] per [0:15];

    always #2.5 clk = ~clk;

    assign bus_gnt   = bus_req && gnt_allow;
    assign bus_rdata = bus_space ? per[bus_addr[3:0]] : rf[bus_addr[7:0]];

    pdma_channel uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .trig_in(trig_in), .en_o(en_o),
        .cur_addr_o(cur_addr_o), .irq_o(irq_o), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_space(bus_space), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        if (bus_wr) begin
            if (bus_space) per[bus_addr[3:0]] <= bus_wdata;
            else           rf[bus_addr[7:0]]  <= bus_wdata;
        end
        if ((bus_rd || bus_wr) && !bus_gnt) viol++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ctl(input logic en, input logic dir, input logic word,
                                        input logic ie, input logic lp, input logic [1:0] sel);
        return {5'd0, sel, lp, ie, word, dir, en};
    endfunction

    task automatic wcfg(input logic [1:0] sel, input logic [11:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        trig_in[line] = 1'b1;
        @(negedge clk);
        trig_in = '0;
    endtask

    // Trigger one transfer, follow it to the end and report the interrupt and request drop.
    task automatic xfer(input int line, output logic irq_seen, output logic drop_ok);
        logic prev_wr = 1'b0;
        int   t = 0;
        pulse(line);
        irq_seen = 1'b0;
        drop_ok  = 1'b0;
        while (!bus_req && t < 50) begin @(negedge clk); t++; end
        while (bus_req && t < 100) begin
            prev_wr = bus_wr;
            @(negedge clk);
            t++;
        end
        drop_ok  = prev_wr && !bus_req;
        irq_seen = irq_o;
    endtask

    // Wait a few cycles and report whether the bus request ever went high.
    task automatic quiet(input int n, output logic stayed);
        stayed = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_req) stayed = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R2 reset req", bus_req, 0);
        chk("R8 reset en", en_o, 0);
        chk("R7 reset irq", irq_o, 0);
        chk("R6 reset cur", cur_addr_o, 0);
    endtask

    task automatic t_byte_loop;
        logic ir, dr;
        wcfg(2'd1, 12'h010);
        chk("R10 load while off", cur_addr_o, 12'h010);
        wcfg(2'd2, 12'h012);
        wcfg(2'd3, 12'h003);
        wcfg(2'd0, ctl(1, 0, 0, 1, 1, 0));
        xfer(0, ir, dr);
        chk("R4 periph to rf", rf[8'h10], 8'h33);
        chk("R5 step by 1", cur_addr_o, 12'h011);
        chk("R7 no irq mid block", ir, 0);
        chk("R9 req drop", dr, 1);
        xfer(0, ir, dr);
        chk("R5 second step", cur_addr_o, 12'h012);
        xfer(0, ir, dr);
        chk("R3 byte at end", rf[8'h12], 8'h33);
        chk("R6 reload", cur_addr_o, 12'h010);
        chk("R7 irq at end", ir, 1);
        chk("R8 loop keeps en", en_o, 1);
    endtask

    task automatic t_word_single;
        logic ir, dr;
        wcfg(2'd0, 12'h000);
        wcfg(2'd1, 12'h020);
        wcfg(2'd2, 12'h022);
        wcfg(2'd3, 12'h005);
        wcfg(2'd0, ctl(1, 1, 1, 0, 0, 1));
        xfer(1, ir, dr);
        chk("R3 word low byte", per[5], 8'h85);
        chk("R3 word high byte", per[6], 8'h84);
        chk("R5 step by 2", cur_addr_o, 12'h022);
        chk("R9 word req drop", dr, 1);
        xfer(1, ir, dr);
        chk("R4 rf to periph low", per[5], 8'h87);
        chk("R4 rf to periph high", per[6], 8'h86);
        chk("R6 word reload", cur_addr_o, 12'h020);
        chk("R8 single pass clears en", en_o, 0);
        chk("R7 irq masked", ir, 0);
    endtask

    task automatic t_disabled;
        logic st;
        pulse(1);
        quiet(6, st);
        chk("R1 disabled trigger ignored", st, 1);
        chk("R1 disabled cur kept", cur_addr_o, 12'h020);
    endtask

    task automatic t_select;
        logic st, ir, dr;
        wcfg(2'd1, 12'h040);
        wcfg(2'd2, 12'h04F);
        wcfg(2'd3, 12'h007);
        wcfg(2'd0, ctl(1, 0, 0, 0, 1, 2));
        pulse(0);
        quiet(6, st);
        chk("R1 unselected line ignored", st, 1);
        chk("R1 unselected cur kept", cur_addr_o, 12'h040);
        xfer(2, ir, dr);
        chk("R1 selected line served", rf[8'h40], 8'h37);
        chk("R5 selected step", cur_addr_o, 12'h041);
    endtask

    task automatic t_start_load;
        wcfg(2'd1, 12'h060);
        chk("R10 no load while on", cur_addr_o, 12'h041);
        wcfg(2'd0, 12'h000);
        wcfg(2'd1, 12'h060);
        chk("R10 load after disable", cur_addr_o, 12'h060);
    endtask

    task automatic t_grant_busy;
        logic st;
        int   t = 0;
        wcfg(2'd2, 12'h06F);
        wcfg(2'd3, 12'h002);
        wcfg(2'd0, ctl(1, 0, 0, 0, 1, 0));
        gnt_allow = 1'b0;
        pulse(0);
        @(negedge clk);
        chk("R2 req raised", bus_req, 1);
        chk("R2 no beat without grant", bus_rd | bus_wr, 0);
        pulse(0);
        repeat (4) @(negedge clk);
        chk("R2 still waiting", bus_req && !bus_rd && !bus_wr, 1);
        gnt_allow = 1'b1;
        while (bus_req && t < 50) begin @(negedge clk); t++; end
        chk("R3 granted byte", rf[8'h60], 8'h32);
        chk("R5 granted step", cur_addr_o, 12'h061);
        quiet(6, st);
        chk("R1 busy trigger not queued", st, 1);
        chk("R1 busy cur kept", cur_addr_o, 12'h061);
        chk("R2 grant violations", viol, 0);
    endtask

    task automatic t_collision;
        logic ir, dr;
        int   t = 0;
        wcfg(2'd0, 12'h000);
        wcfg(2'd1, 12'h070);
        wcfg(2'd2, 12'h070);
        wcfg(2'd3, 12'h004);
        wcfg(2'd0, ctl(1, 0, 0, 1, 0, 0));
        pulse(0);
        while (!bus_wr && t < 50) begin @(negedge clk); t++; end
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = ctl(1, 0, 0, 1, 1, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R11 software write wins", en_o, 1);
        chk("R11 irq still fires", irq_o, 1);
        chk("R6 collision reload", cur_addr_o, 12'h070);
        per[4] = 8'h5A;
        xfer(0, ir, dr);
        chk("R11 channel still serves", rf[8'h70], 8'h5A);
        chk("R8 looping after write", en_o, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) rf[i] = 8'(i) ^ 8'hA5;
        for (int i = 0; i < 16; i++) per[i] = 8'h30 + 8'(i);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_byte_loop;
        t_word_single;
        t_disabled;
        t_select;
        t_start_load;
        t_grant_busy;
        t_collision;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule